// File: doc/BRIEF.md
# Nine-Bit Parallel-Load / Serial-Shift Register

This block holds a nine-bit word, sized for one data byte and its parity bit. Each operation either loads all nine bits from a parallel input word or moves the contents one place up, from bit 0 toward bit 8. In shift mode a serial input fills bit 0 and the old top bit is lost. The nine bits appear on a parallel output bus. A combinational flag tells whether the stored word has odd weight, so a receiver can test even parity on the byte and its parity bit.

Two separate trigger inputs can start an operation. Both are treated as asynchronous edge requests. Each one passes through a short synchroniser into the single system clock domain, and a rising edge is detected there. If both inputs rise in the same system cycle, only one operation is performed. The mode, the serial bit and the parallel word are sampled in the system cycle that performs the operation. An active-high clear input zeroes the word at once, with no clock needed. All pins are plain control and data signals, and there is no handshake at the block's edge.

Top module: `pword_shift_reg`

## Requirements
- R1: While `master_clr` is high, `word_out` is all zero. The clear takes effect asynchronously, without a `sys_clk` edge, and it overrides any pending operation.
- R2: In a cycle that performs an operation with `mode_shift` = 0, the register loads `par_in`, with `par_in[i]` going to `word_out[i]` for i = 0..8.
- R3: In a cycle that performs an operation with `mode_shift` = 1, `word_out[0]` takes `ser_in` and `word_out[i]` takes the old `word_out[i-1]` for i = 1..8. The old bit 8 is dropped.
- R4: `trig_a` and `trig_b` each start an operation independently. Suppose a trigger is sampled high at rising `sys_clk` edge k after being sampled low at edge k-1. The operation then happens at edge k+SYNC_STAGES, which is k+2 with the default setting.
- R5: If both triggers produce detected rising edges for the same `sys_clk` edge, exactly one operation is performed.
- R6: The operation uses the values of `mode_shift`, `ser_in` and `par_in` present at the `sys_clk` edge that performs it. Values at earlier edges have no effect.
- R7: At an edge with no detected trigger rise, `word_out` holds. A trigger that stays high, or that falls, starts nothing.
- R8: `parity_odd` is high exactly when an odd number of `word_out` bits are 1, and it follows `word_out` in the same cycle.
- R9: After `master_clr` falls, `word_out` stays zero until the first operation started by a trigger rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; all sampling and updates occur on its rising edge |
| master_clr | input | 1 | Asynchronous active-high clear of the word and the trigger synchronisers |
| trig_a | input | 1 | First trigger request; its rising edge starts one operation |
| trig_b | input | 1 | Second trigger request; its rising edge starts one operation |
| mode_shift | input | 1 | 0 selects a parallel load, 1 selects a one-place shift |
| ser_in | input | 1 | Serial bit that enters bit 0 during a shift |
| par_in | input | 9 | Parallel word for a load |
| word_out | output | 9 | Stored word, bit i on line i |
| parity_odd | output | 1 | High when the stored word has an odd number of ones |

## Verification
A trigger rise first sampled at edge k changes the word at edge k+2. The parity flag follows the word in the same cycle. A clear empties the word within a fraction of a nanosecond. The bench runs a reference model that records the history of trigger samples in queues and updates its word at every rising edge. It compares `word_out` and `parity_odd` at the following falling edge, so each expected value is compared in the half cycle after the edge that is due to produce it. Clears are applied between edges and checked 1 ns later, before any clock edge, to show that they act without the clock.

// File: rtl/pword_pkg.sv
package pword_pkg;

  localparam int WORD_W = 9;
  localparam int SYNC_W = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;

endpackage

// File: rtl/pword_edge_det.sv
module pword_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic trig,
  output logic rise
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= (sync_q << 1) | SYNC_STAGES'(trig);
      prev_q <= sync_q[TOP];
    end
  end

  assign rise = sync_q[TOP] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (clr)
    rise |=> !rise); // R4

endmodule

// File: rtl/pword_core.sv
module pword_core
  import pword_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             fire,
  input  logic             mode_shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] word_q
);

  op_e              op;
  logic [WIDTH-1:0] word_d;

  always_comb begin
    if (!fire)          op = OP_HOLD;
    else if (mode_shift) op = OP_SHIFT;
    else                op = OP_LOAD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  word_d = par_in;
      OP_SHIFT: word_d = {word_q[WIDTH-2:0], ser_in};
      default:  word_d = word_q;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) word_q <= '0;
    else     word_q <= word_d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    !fire |=> $stable(word_q)); // R7

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (clr)
    (fire && !mode_shift) |=> (word_q == $past(par_in))); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (clr)
    (fire && mode_shift) |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(ser_in)})); // R3

endmodule

// File: rtl/pword_parity.sv
module pword_parity #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] word,
  output logic             odd
);

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ word[i];
  end

  assign odd = chain[WIDTH];

endmodule

// File: rtl/pword_shift_reg.sv
module pword_shift_reg
  import pword_pkg::*;
#(
  parameter int WIDTH       = WORD_W,
  parameter int SYNC_STAGES = SYNC_W
) (
  input  logic             sys_clk,
  input  logic             master_clr,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             mode_shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] word_out,
  output logic             parity_odd
);

  localparam int NUM_TRIG = 2;

  logic [NUM_TRIG-1:0] trig_vec;
  logic [NUM_TRIG-1:0] rise_vec;
  logic                fire;

  assign trig_vec = {trig_b, trig_a};

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    pword_edge_det #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
      .clk  (sys_clk),
      .clr  (master_clr),
      .trig (trig_vec[t]),
      .rise (rise_vec[t])
    );
  end

  assign fire = |rise_vec;

  pword_core #(
    .WIDTH(WIDTH)
  ) u_core (
    .clk        (sys_clk),
    .clr        (master_clr),
    .fire       (fire),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .word_q     (word_out)
  );

  pword_parity #(
    .WIDTH(WIDTH)
  ) u_parity (
    .word (word_out),
    .odd  (parity_odd)
  );

  AST_ZERO_AFTER_CLR: assert property (@(posedge sys_clk) disable iff (master_clr)
    $past(master_clr) |-> (word_out == '0)); // R9

  AST_BOTH_ONE_OP: assert property (@(posedge sys_clk) disable iff (master_clr)
    (&rise_vec && mode_shift && !ser_in) |=> (word_out[0] == 1'b0)); // R5

endmodule

// File: tb/pword_shift_reg_bench.sv
module pword_shift_reg_bench;

  localparam int W  = 9;
  localparam int SS = 2;

  logic         sys_clk = 1'b0;
  logic         master_clr;
  logic         trig_a, trig_b;
  logic         mode_shift, ser_in;
  logic [W-1:0] par_in;
  logic [W-1:0] word_out;
  logic         parity_odd;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  bit           ha[$];
  bit           hb[$];
  logic [W-1:0] model;
  string        op_tag;
  string        phase;

  always #10 sys_clk = ~sys_clk;

  pword_shift_reg u_pword_shift_reg (
    .sys_clk    (sys_clk),
    .master_clr (master_clr),
    .trig_a     (trig_a),
    .trig_b     (trig_b),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .word_out   (word_out),
    .parity_odd (parity_odd)
  );

  function automatic void clear_model();
    model = '0;
    ha.delete();
    hb.delete();
    for (int i = 0; i <= SS; i++) begin
      ha.push_back(1'b0);
      hb.push_back(1'b0);
    end
  endfunction

  function automatic bit odd_weight(logic [W-1:0] v);
    int ones = 0;
    for (int i = 0; i < W; i++) if (v[i]) ones++;
    return (ones % 2) == 1;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (%s): actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  // reference update at a rising edge, using input values present at that edge
  task automatic model_edge();
    bit ea, eb;
    if (master_clr) begin
      clear_model();
      op_tag = "R1";
      return;
    end
    ea = ha[SS-1] && !ha[SS];
    eb = hb[SS-1] && !hb[SS];
    ha.push_front(trig_a); void'(ha.pop_back());
    hb.push_front(trig_b); void'(hb.pop_back());
    if (ea || eb) begin
      if (mode_shift) begin
        for (int i = W - 1; i > 0; i--) model[i] = model[i-1];
        model[0] = ser_in;
        op_tag = (ea && eb) ? "R5" : "R3";
      end else begin
        model = par_in;
        op_tag = (ea && eb) ? "R5" : "R2";
      end
    end else begin
      op_tag = "R7";
    end
  endtask

  task automatic cyc();
    @(posedge sys_clk);
    model_edge();
    @(negedge sys_clk);
    check(op_tag, word_out, model);
    check("R8", W'(parity_odd), W'(odd_weight(model)));
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(bit a, bit b, int hi);
    trig_a = a; trig_b = b;
    cycles(hi);
    trig_a = 1'b0; trig_b = 1'b0;
    cycles(SS + 1);
  endtask

  task automatic async_clear();
    #5 master_clr = 1'b1;
    #1 clear_model();
    phase = "async clear";
    check("R1", word_out, '0);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    master_clr = 1'b1;
    trig_a = 0; trig_b = 0; mode_shift = 0; ser_in = 0;
    par_in = '1;
    clear_model();
    phase = "reset";
    cycles(3);
    check("R1", word_out, '0);
    @(negedge sys_clk);
    master_clr = 1'b0;

    // R9: no trigger, word stays zero with parallel data present
    phase = "post-clear idle";
    par_in = 9'h1FF;
    cycles(4);
    check("R9", word_out, '0);

    // R2 / R4: load via trigger A, exact latency
    phase = "load A latency";
    par_in = 9'h1A5;
    trig_a = 1'b1;
    cyc();
    check("R4", word_out, '0);
    cyc();
    check("R4", word_out, '0);
    cyc();
    check("R4", word_out, 9'h1A5);
    trig_a = 1'b0;
    cycles(3);

    // R4: load via trigger B
    phase = "load B";
    par_in = 9'h05A;
    pulse(1'b0, 1'b1, 2);
    check("R4", word_out, 9'h05A);

    // R3: shift a pattern through, alternating triggers
    phase = "shift";
    mode_shift = 1'b1;
    for (int s = 0; s < 11; s++) begin
      ser_in = s[0] ^ s[2];
      pulse(s[0], !s[0], 1 + (s % 2));
    end

    // R5: both triggers rise together, one shift only
    phase = "both";
    par_in = 9'h000;
    mode_shift = 1'b0;
    pulse(1'b1, 1'b0, 1);
    par_in = 9'h0F1;
    pulse(1'b1, 1'b0, 1);
    mode_shift = 1'b1;
    ser_in = 1'b0;
    pulse(1'b1, 1'b1, 2);
    check("R5", word_out, 9'h1E2);

    // R7: trigger held high, data wiggling, nothing happens
    phase = "held";
    trig_a = 1'b1;
    cycles(SS + 1);
    for (int i = 0; i < 8; i++) begin
      par_in = W'($urandom);
      mode_shift = i[0];
      ser_in = i[1];
      cyc();
    end
    trig_a = 1'b0;
    for (int i = 0; i < 4; i++) begin
      par_in = W'($urandom);
      cyc();
    end

    // R6: inputs change every cycle while a trigger is pending
    phase = "late sample";
    mode_shift = 1'b0;
    trig_b = 1'b1;
    par_in = 9'h111;
    cyc();
    par_in = 9'h0C3;
    mode_shift = 1'b1;
    cyc();
    par_in = 9'h13C;
    mode_shift = 1'b0;
    cyc();
    check("R6", word_out, 9'h13C);
    trig_b = 1'b0;
    cycles(3);

    // random mixed traffic
    phase = "mixed";
    for (int i = 0; i < 40; i++) begin
      par_in = W'($urandom);
      mode_shift = $urandom_range(0, 1);
      ser_in = $urandom_range(0, 1);
      trig_a = $urandom_range(0, 1);
      trig_b = $urandom_range(0, 1);
      cyc();
    end
    trig_a = 0; trig_b = 0;
    cycles(4);

    // R1 / R9: asynchronous clear with a pending trigger
    phase = "clear";
    mode_shift = 1'b0;
    par_in = 9'h1C7;
    pulse(1'b1, 1'b0, 2);
    trig_a = 1'b1;
    cyc();
    async_clear();
    cycles(2);
    check("R1", word_out, '0);
    trig_a = 1'b0;
    @(negedge sys_clk);
    master_clr = 1'b0;
    phase = "after clear";
    cycles(5);
    check("R9", word_out, '0);
    par_in = 9'h0AB;
    pulse(1'b0, 1'b1, 1);
    check("R9", word_out, 9'h0AB);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule